// File: doc/BRIEF.md
# Host Port Command Dispatcher

This block sits behind one 32-bit host-writable register of a network controller. The host may write the register in a single 32-bit access, as two 16-bit halves or as four single bytes. Every write is merged into a holding word by byte enables. A command is taken only on the write that covers the most significant byte, so that byte must come last in a split sequence.

The accepted word carries a 4-bit opcode in its low nibble and a 16-byte-aligned pointer in the upper 28 bits. The block decodes the opcode into one of five one-cycle start pulses: software reset, self-test, selective reset, dump or wake-up dump. The pulse comes with the pointer expanded to a byte address. An unknown opcode gives a one-cycle error pulse and nothing else.

A software reset clears the holding word. It then holds the block busy for a recovery period of ten system clocks plus five transmit clocks, counted in system clocks. During that period reads return zero and writes are dropped. Any other operation keeps the block busy until the engine that carries it out reports completion.

Top module: `port_cmd_dispatch`

## Requirements
- R1: A write updates only the byte lanes whose enable is set, where enable bit k covers data bits 8k+7:8k. The merged word is visible on `host_rdata` from the cycle after the write.
- R2: A write whose enable bit 3 is clear never produces a start or error pulse. It only merges.
- R3: A write with enable bit 3 set, accepted while not busy, decodes bits 3:0 of the merged word in the following cycle. The codes are 0000 → `go_sw_reset`, 0001 → `go_self_test`, 0010 → `go_sel_reset`, 0011 → `go_dump` and 0111 → `go_wake_dump`. Each is a pulse of exactly one cycle, and at most one of them is high at a time.
- R4: In the cycle a start pulse is high, `target_addr` equals merged bits 31:4 followed by four zero bits.
- R5: Any other opcode raises `bad_cmd` for one cycle with no start pulse. Busy stays low and the holding word keeps the written value.
- R6: A software reset clears the holding word to zero. `busy` is then high for exactly RECOVERY = SYS_WAIT + TX_WAIT·TX_DIV cycles (30 by default), starting in the cycle of the pulse.
- R7: While the reset recovery runs, `host_rdata` reads zero and writes are ignored, including writes that carry a command.
- R8: After self-test, selective reset, dump or wake-up dump, `busy` stays high until `op_done` is seen. Writes made while busy change nothing and fire nothing.
- R9: With WAKE_DUMP_EN = 0, opcode 0111 is handled as unknown, as described in R5.
- R10: After reset, `busy`, all pulses, `target_addr` and `host_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_be | input | 4 | Byte-lane enables of the write |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Holding word readback (zero during reset recovery) |
| op_done | input | 1 | Completion from the engine running a non-reset operation |
| busy | output | 1 | Recovery or operation in progress; writes dropped |
| go_sw_reset | output | 1 | Software reset start pulse |
| go_self_test | output | 1 | Self-test start pulse |
| go_sel_reset | output | 1 | Selective reset start pulse |
| go_dump | output | 1 | Dump start pulse |
| go_wake_dump | output | 1 | Wake-up dump start pulse |
| target_addr | output | 32 | Byte address of the result or dump area |
| bad_cmd | output | 1 | Unknown-opcode pulse |

## Verification
Several properties are checked on every cycle. The holding word stays frozen while busy. Pulses are mutually exclusive and last one cycle. A write that skips the top byte never fires. A software reset always raises busy, and an error never leaves the block busy. Only the bench scenarios can show that the pulse matches the opcode and the address, and that busy lasts exactly the recovery count. The same goes for zero readback and the cleared word after a reset, lane merging across the 32-, 16- and 8-bit write styles, and the variant without wake-up dump.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

   typedef enum logic [3:0] {
      OPC_SW_RESET  = 4'h0,
      OPC_SELF_TEST = 4'h1,
      OPC_SEL_RESET = 4'h2,
      OPC_DUMP      = 4'h3,
      OPC_WAKE_DUMP = 4'h7
   } opc_e;

   localparam int NUM_OPS      = 5;
   localparam int IDX_SW_RESET = 0;
   localparam int IDX_SELFTEST = 1;
   localparam int IDX_SELRESET = 2;
   localparam int IDX_DUMP     = 3;
   localparam int IDX_WAKEDUMP = 4;
   localparam int OPC_W        = 4;

   typedef struct packed {
      logic [NUM_OPS-1:0] start;
      logic               err;
   } dec_t;

endpackage

// File: rtl/pcd_merge.sv
module pcd_merge #(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [LANES-1:0]  be,
   input  logic [DATA_W-1:0] wdata,
   input  logic              accept,
   input  logic              clear,
   output logic              fire,
   output logic [DATA_W-1:0] merged,
   output logic [DATA_W-1:0] hold_q
);

   logic take;
   assign take = wr && accept;
   assign fire = take && be[LANES-1];

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign merged[8*k +: 8] = be[k] ? wdata[8*k +: 8] : hold_q[8*k +: 8];

      // R1: an accepted write that leaves lane k unselected keeps that lane
      p_lane_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (take && !be[k] && !(fire && clear)) |=> $stable(hold_q[8*k +: 8]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hold_q <= '0;
      else if (fire && clear)
         hold_q <= '0;
      else if (take)
         hold_q <= merged;
   end

   // R7/R8: nothing written while the block refuses writes
   p_frozen_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(hold_q));

endmodule

// File: rtl/pcd_decode.sv
module pcd_decode
   import pcd_pkg::*;
#(
   parameter bit WAKE_DUMP_EN = 1'b1
) (
   input  logic [OPC_W-1:0] opc,
   input  logic             fire,
   output dec_t             dec
);

   logic [NUM_OPS-1:0] hit;
   logic               wake_hit;

   always_comb begin
      hit = '0;
      unique case (opc)
         OPC_SW_RESET:  hit[IDX_SW_RESET] = 1'b1;
         OPC_SELF_TEST: hit[IDX_SELFTEST] = 1'b1;
         OPC_SEL_RESET: hit[IDX_SELRESET] = 1'b1;
         OPC_DUMP:      hit[IDX_DUMP]     = 1'b1;
         default:       hit = '0;
      endcase
   end

   if (WAKE_DUMP_EN) begin : g_wake
      assign wake_hit = (opc == OPC_WAKE_DUMP);
   end else begin : g_no_wake
      assign wake_hit = 1'b0;
   end

   always_comb begin
      dec.start               = fire ? hit : '0;
      dec.start[IDX_WAKEDUMP] = fire && wake_hit;
      dec.err                 = fire && !wake_hit && (hit == '0);
   end

endmodule

// File: rtl/pcd_seq.sv
module pcd_seq
   import pcd_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int RECOVERY = 30,
   localparam int CNT_W   = $clog2(RECOVERY + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  dec_t               dec,
   input  logic [ADDR_W-1:0]  addr_in,
   input  logic               op_done,
   output logic [NUM_OPS-1:0] start_q,
   output logic               err_q,
   output logic [ADDR_W-1:0]  addr_q,
   output logic               rec_busy,
   output logic               op_active
);

   logic [CNT_W-1:0] rec_cnt;
   logic             any_start;

   assign any_start = |dec.start;
   assign rec_busy  = (rec_cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q   <= '0;
         err_q     <= 1'b0;
         addr_q    <= '0;
         rec_cnt   <= '0;
         op_active <= 1'b0;
      end else begin
         start_q <= dec.start;
         err_q   <= dec.err;
         if (rec_busy)
            rec_cnt <= rec_cnt - 1'b1;
         if (op_done)
            op_active <= 1'b0;
         if (any_start)
            addr_q <= addr_in;
         if (dec.start[IDX_SW_RESET])
            rec_cnt <= CNT_W'(RECOVERY);
         else if (any_start)
            op_active <= 1'b1;
      end
   end

   // R3: at most one pulse of any kind per cycle
   p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_q, err_q}));
   // R3: every start pulse lasts a single cycle
   p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|start_q) |=> (start_q == '0));
   // R6: software reset always enters recovery
   p_reset_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start_q[IDX_SW_RESET] |-> rec_busy);
   // R5: an error never leaves the block busy
   p_err_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> (!rec_busy && !op_active));

endmodule

// File: rtl/port_cmd_dispatch.sv
module port_cmd_dispatch
   import pcd_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int ALIGN_BITS   = 4,
   parameter int SYS_WAIT     = 10,
   parameter int TX_WAIT      = 5,
   parameter int TX_DIV       = 4,
   parameter bit WAKE_DUMP_EN = 1'b1,
   localparam int LANES       = DATA_W / 8,
   localparam int RECOVERY    = SYS_WAIT + TX_WAIT * TX_DIV
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [LANES-1:0]  host_be,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              op_done,
   output logic              busy,
   output logic              go_sw_reset,
   output logic              go_self_test,
   output logic              go_sel_reset,
   output logic              go_dump,
   output logic              go_wake_dump,
   output logic [DATA_W-1:0] target_addr,
   output logic              bad_cmd
);

   if ((DATA_W % 8) != 0 || DATA_W < 16) begin : g_bad_width
      $error("port_cmd_dispatch: DATA_W must be a multiple of 8 and at least 16");
   end
   if (ALIGN_BITS < OPC_W) begin : g_bad_align
      $error("port_cmd_dispatch: ALIGN_BITS must cover the opcode field");
   end
   if (SYS_WAIT < 1 || TX_WAIT < 0 || TX_DIV < 1) begin : g_bad_wait
      $error("port_cmd_dispatch: recovery parameters out of range");
   end

   logic               fire;
   logic [DATA_W-1:0]  merged, hold_q, addr_next;
   dec_t               dec;
   logic [NUM_OPS-1:0] start_q;
   logic               rec_busy, op_active;

   assign busy = rec_busy || op_active;

   pcd_merge #(.DATA_W(DATA_W)) u_merge (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (host_wr),
      .be     (host_be),
      .wdata  (host_wdata),
      .accept (!busy),
      .clear  (dec.start[IDX_SW_RESET]),
      .fire   (fire),
      .merged (merged),
      .hold_q (hold_q)
   );

   pcd_decode #(.WAKE_DUMP_EN(WAKE_DUMP_EN)) u_decode (
      .opc  (merged[OPC_W-1:0]),
      .fire (fire),
      .dec  (dec)
   );

   assign addr_next = {merged[DATA_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};

   pcd_seq #(.ADDR_W(DATA_W), .RECOVERY(RECOVERY)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .dec       (dec),
      .addr_in   (addr_next),
      .op_done   (op_done),
      .start_q   (start_q),
      .err_q     (bad_cmd),
      .addr_q    (target_addr),
      .rec_busy  (rec_busy),
      .op_active (op_active)
   );

   assign go_sw_reset  = start_q[IDX_SW_RESET];
   assign go_self_test = start_q[IDX_SELFTEST];
   assign go_sel_reset = start_q[IDX_SELRESET];
   assign go_dump      = start_q[IDX_DUMP];
   assign go_wake_dump = start_q[IDX_WAKEDUMP];
   assign host_rdata   = rec_busy ? '0 : hold_q;

   // R2: a write missing the top lane never fires anything
   p_no_fire_wo_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && !host_be[LANES-1]) |=> (start_q == '0 && !bad_cmd));
   // R7: recovery reads back zero
   p_rd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rec_busy |-> (host_rdata == '0));

endmodule

// File: tb/port_cmd_dispatch_tb_top.sv
`timescale 1ns/1ps
module port_cmd_dispatch_tb_top;

   localparam int RECOV = 30;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [3:0]  host_be = '0;
   logic [31:0] host_wdata = '0;
   logic        op_done = 1'b0;
   logic [31:0] host_rdata, target_addr;
   logic        busy, go_sw_reset, go_self_test, go_sel_reset, go_dump, go_wake_dump, bad_cmd;

   logic        l_wr = 1'b0;
   logic [3:0]  l_be = '0;
   logic [31:0] l_wdata = '0;
   logic [31:0] l_rdata, l_addr;
   logic        l_busy, l_sw, l_st, l_sr, l_dm, l_wd, l_err;

   int nchk = 0;
   int nfail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   port_cmd_dispatch dut_i (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_be(host_be),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .op_done(op_done),
      .busy(busy), .go_sw_reset(go_sw_reset), .go_self_test(go_self_test),
      .go_sel_reset(go_sel_reset), .go_dump(go_dump), .go_wake_dump(go_wake_dump),
      .target_addr(target_addr), .bad_cmd(bad_cmd));

   port_cmd_dispatch #(.WAKE_DUMP_EN(1'b0)) lite_i (
      .clk(clk), .rst_n(rst_n), .host_wr(l_wr), .host_be(l_be),
      .host_wdata(l_wdata), .host_rdata(l_rdata), .op_done(1'b0),
      .busy(l_busy), .go_sw_reset(l_sw), .go_self_test(l_st),
      .go_sel_reset(l_sr), .go_dump(l_dm), .go_wake_dump(l_wd),
      .target_addr(l_addr), .bad_cmd(l_err));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_merge(input logic [31:0] old, input logic [3:0] be, input logic [31:0] d);
      logic [31:0] r = old;
      for (int k = 0; k < 4; k++) if (be[k]) r[8*k +: 8] = d[8*k +: 8];
      return r;
   endfunction

   // pulse vector {sw, st, sr, dump, wake, err} expected for an opcode
   function automatic logic [5:0] exp_pulses(input logic [3:0] opc, input bit wake_en);
      case (opc)
         4'h0: return 6'b100000;
         4'h1: return 6'b010000;
         4'h2: return 6'b001000;
         4'h3: return 6'b000100;
         4'h7: return wake_en ? 6'b000010 : 6'b000001;
         default: return 6'b000001;
      endcase
   endfunction

   function automatic logic [5:0] pulses();
      return {go_sw_reset, go_self_test, go_sel_reset, go_dump, go_wake_dump, bad_cmd};
   endfunction

   task automatic wr(input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_be = be; host_wdata = d;
      @(posedge clk); #1;
      host_wr = 1'b0; host_be = '0;
   endtask

   // issue one command in a chosen write style; returns after the firing edge
   task automatic issue(input logic [31:0] w, input int style);
      logic [31:0] sh = host_rdata;
      case (style)
         0: ;
         1: begin
            wr(4'b0011, w); sh = exp_merge(sh, 4'b0011, w);
            chk(pulses() == 6'b0, "R2 16-bit low half fired", 32'(pulses()), 0);
            chk(host_rdata == sh, "R1 16-bit merge", host_rdata, sh);
         end
         default: begin
            for (int k = 0; k < 3; k++) begin
               wr(4'b0001 << k, w); sh = exp_merge(sh, 4'b0001 << k, w);
               chk(pulses() == 6'b0, "R2 byte write fired", 32'(pulses()), 0);
               chk(host_rdata == sh, "R1 byte merge", host_rdata, sh);
            end
         end
      endcase
      case (style)
         0: wr(4'b1111, w);
         1: wr(4'b1100, w);
         default: wr(4'b1000, w);
      endcase
   endtask

   task automatic run_cmd(input logic [31:0] w, input int style);
      logic [5:0] ep = exp_pulses(w[3:0], 1'b1);
      logic [31:0] junk;
      int cnt;
      issue(w, style);
      chk(pulses() == ep, "R3 R5 pulse select", 32'(pulses()), 32'(ep));
      if (ep[0]) begin
         chk(!busy && host_rdata == w, "R5 error leaves idle and word kept", host_rdata, w);
         @(posedge clk); #1;
         chk(!bad_cmd, "R5 error one cycle", 32'(bad_cmd), 0);
      end else begin
         chk(target_addr == {w[31:4], 4'h0}, "R4 target address", target_addr, {w[31:4], 4'h0});
         if (ep[5]) begin
            cnt = 0;
            while (busy && cnt < 100) begin
               cnt++;
               chk(host_rdata == 0, "R7 read zero in recovery", host_rdata, 0);
               if (cnt == 3) chk(pulses() == 6'b0, "R7 write in recovery fired", 32'(pulses()), 0);
               host_wr = (cnt == 2); host_be = 4'hF; host_wdata = 32'h0000_0010 | $urandom;
               @(posedge clk); #1;
            end
            host_wr = 1'b0;
            chk(cnt == RECOV, "R6 recovery length", cnt, RECOV);
            chk(host_rdata == 0, "R6 R7 word cleared", host_rdata, 0);
         end else begin
            chk(busy, "R8 busy after start", 32'(busy), 1);
            junk = {$urandom} & 32'hFFFF_FFF0 | 32'h1;
            wr(4'hF, junk);
            chk(pulses() == 6'b0 && host_rdata == w, "R8 write while busy", host_rdata, w);
            @(negedge clk); op_done = 1'b1;
            @(posedge clk); #1; op_done = 1'b0;
            chk(!busy, "R8 busy released by op_done", 32'(busy), 0);
         end
      end
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin
      logic [31:0] w, sh;
      logic [3:0]  be, opc;
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      #1;
      chk(!busy && pulses() == 0 && target_addr == 0 && host_rdata == 0,
          "R10 reset state", host_rdata | 32'(busy), 0);
      @(negedge clk); rst_n = 1'b1;

      // R1 random lower-lane merges, no top byte (R2)
      sh = 0;
      for (int i = 0; i < 20; i++) begin
         be = 4'($urandom) & 4'b0111; w = $urandom;
         wr(be, w); sh = exp_merge(sh, be, w);
         chk(host_rdata == sh, "R1 lane merge", host_rdata, sh);
         chk(pulses() == 0, "R2 no top byte no fire", 32'(pulses()), 0);
      end

      // directed: each opcode once, each style
      run_cmd(32'h1234_5673, 2);
      run_cmd(32'hABCD_EF01, 1);
      run_cmd(32'h0000_0F02, 0);
      run_cmd(32'hFFFF_FFF7, 2);
      run_cmd(32'h8000_000C, 1);
      run_cmd(32'hDEAD_BEE0, 0);

      // random mix
      for (int i = 0; i < 40; i++) begin
         case ($urandom_range(0, 6))
            0: opc = 4'h0;
            1: opc = 4'h1;
            2: opc = 4'h2;
            3: opc = 4'h3;
            4: opc = 4'h7;
            default: opc = 4'($urandom);
         endcase
         w = {28'($urandom), opc};
         run_cmd(w, $urandom_range(0, 2));
      end

      // R9 variant without wake-up dump
      @(negedge clk); l_wr = 1'b1; l_be = 4'hF; l_wdata = 32'h0000_1237;
      @(posedge clk); #1; l_wr = 1'b0;
      chk(l_err && !l_wd && !l_busy, "R9 wake dump disabled gives error",
          {l_err, l_wd, l_busy}, 32'b100);
      @(negedge clk); l_wr = 1'b1; l_be = 4'hF; l_wdata = 32'h0000_1233;
      @(posedge clk); #1; l_wr = 1'b0;
      chk(l_dm && l_addr == 32'h0000_1230, "R9 variant still dumps", l_addr, 32'h0000_1230);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule